// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Status Unit

The block gathers up to 64 interrupt sources into one shared pending register. A rising edge on a source input latches that source as pending. The bit then stays set until software acknowledges it. To acknowledge, software writes ones to a dedicated clear address. Each one in the written word drops the matching pending bit. Writing all ones drops every pending bit at once.

Each of four CPUs owns a 64-bit enable mask. A CPU sees the pending word ANDed with its own mask. Each CPU has two request outputs:

- The first request covers the low 16 sources, which form the level-0 group.
- The second request covers the remaining sources.

Masks are plain read/write registers. Software can therefore read a mask, change single bits and write it back without disturbing the other bits.

Access uses a small single-cycle bus. Reads are combinational from the address. The word map is:

| Address | Register | Access |
|---|---|---|
| 0 | pending word | read-only |
| 1 | clear port | write-one-to-clear, reads zero |
| 2 + c | mask of CPU c, for c = 0 to 3 | read/write |
| 6 and 7 | unmapped | read zero, writes ignored |

Top module: `intr_status_unit`

## Requirements
- R1: After reset the pending word, all four masks, the clear-port readback and every request output read zero.
- R2: A 0-to-1 transition on `src_i[n]`, seen at a clock edge, sets pending bit n at that edge. A source held high does not set its bit again after it has been cleared.
- R3: A pending bit stays set until a clear-port write (address 1) carries a one at its position. Zeros in the clear word leave bits unchanged.
- R4: Writing all ones to the clear port (address 1) clears every pending bit for which no rising edge arrives in the same cycle.
- R5: When a rising edge and a clear of the same bit fall in the same cycle, the bit is left set.
- R6: A write to address 2+c loads the mask of CPU c, which reads back unchanged. The other masks are not affected, so read-modify-write updates single bits.
- R7: `irq_l0[c]` is high exactly when (pending AND mask c) has a one in bits 15:0.
- R8: `irq_hi[c]` is high exactly when (pending AND mask c) has a one in bits 63:16.
- R9: Writes to address 0 do not change the pending word, and address 1 reads as zero.
- R10: Addresses 6 and 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source levels, edge-detected |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational from address |
| irq_l0 | output | 4 | Per-CPU level-0 request (bits 15:0) |
| irq_hi | output | 4 | Per-CPU upper-group request (bits 63:16) |

## Verification
Three kinds of result share one timing rule:

- Source edges and clear or mask writes take effect at the clock edge that samples them.
- Read data follows the address in the same cycle.
- Request outputs follow the registers with no added delay.

Every result is therefore due one edge after its stimulus. The bench drives at the falling edge and compares at the next falling edge. Read values are checked a short settle delay after the address is driven, still away from any rising edge.

// File: rtl/intr_status_unit.sv
module intr_status_unit #(
  parameter int NSRC = 64,
  parameter int NCPU = 4,
  parameter int L0W  = 16,
  parameter int AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_i,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [NSRC-1:0]      bus_wdata,
  output logic [NSRC-1:0]      bus_rdata,
  output logic [NCPU-1:0]      irq_l0,
  output logic [NCPU-1:0]      irq_hi
);
  localparam int A_STAT = 0;
  localparam int A_CLR  = 1;
  localparam int A_MASK = 2;

  logic [NSRC-1:0]            src_q, stat_q, rise, clr;
  logic [NCPU-1:0][NSRC-1:0]  mask_q;

  assign rise = src_i & ~src_q;
  assign clr  = (bus_wr && bus_addr == AW'(A_CLR)) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      stat_q <= '0;
    end else begin
      src_q  <= src_i;
      stat_q <= (stat_q & ~clr) | rise;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NSRC-1:0] pend;

    always_ff @(posedge clk) begin
      if (!rst_n)
        mask_q[c] <= '0;
      else if (bus_wr && bus_addr == AW'(A_MASK + c))
        mask_q[c] <= bus_wdata;
    end

    assign pend      = stat_q & mask_q[c];
    assign irq_l0[c] = |pend[L0W-1:0];
    assign irq_hi[c] = |pend[NSRC-1:L0W];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_STAT))
      bus_rdata = stat_q;
    for (int c = 0; c < NCPU; c++)
      if (bus_addr == AW'(A_MASK + c))
        bus_rdata = mask_q[c];
  end
endmodule

// File: rtl/intr_status_unit_chk.sv
module intr_status_unit_chk #(
  parameter int NSRC = 64,
  parameter int NCPU = 4,
  parameter int AW   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NSRC-1:0]     src_i,
  input logic                bus_wr,
  input logic [AW-1:0]       bus_addr,
  input logic [NSRC-1:0]     bus_wdata,
  input logic [NSRC-1:0]     bus_rdata,
  input logic [NCPU-1:0]     irq_l0,
  input logic [NCPU-1:0]     irq_hi,
  input logic [NSRC-1:0]     src_q,
  input logic [NSRC-1:0]     stat,
  input logic [NCPU-1:0][NSRC-1:0] mask
);
  logic [NSRC-1:0] edge_v, clr_v;
  assign edge_v = src_i & ~src_q;
  assign clr_v  = (bus_wr && bus_addr == AW'(1)) ? bus_wdata : '0;

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_v != '0) |=> ((stat & $past(edge_v)) == $past(edge_v)));

  a_r3_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat & $past(stat & ~clr_v)) == $past(stat & ~clr_v)));

  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(1) && (&bus_wdata) && edge_v == '0) |=> (stat == '0));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_v & clr_v) != '0) |=> ((stat & $past(edge_v & clr_v)) == $past(edge_v & clr_v)));

  for (genvar c = 0; c < NCPU; c++) begin : g_m
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(2 + c)) |=> (mask[c] == $past(bus_wdata)));
  end

  a_r7_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> (irq_l0 == '0 && irq_hi == '0));

  a_r9_stat_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0) && edge_v == '0) |=> (stat == $past(stat)));

  a_r9_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(1)) |-> (bus_rdata == '0));

  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= AW'(2 + NCPU)) |-> (bus_rdata == '0));
endmodule

bind intr_status_unit intr_status_unit_chk #(.NSRC(NSRC), .NCPU(NCPU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_l0(irq_l0), .irq_hi(irq_hi),
  .src_q(src_q), .stat(stat_q), .mask(mask_q)
);

// File: tb/test_intr_status_unit.sv
`timescale 1ns/1ps
module test_intr_status_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src_i = '0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [3:0]  irq_l0, irq_hi;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  intr_status_unit i_intr_status_unit (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_l0(irq_l0), .irq_hi(irq_hi)
  );

  localparam logic [63:0] ONES = '1;
  // {src, clear word, expected pending after the edge}
  localparam logic [191:0] VEC [11] = '{
    {64'h1, 64'h0, 64'h1},
    {64'h1, 64'h0, 64'h1},
    {64'h0, 64'h1, 64'h0},
    {64'h8000_0000_0001_0000, 64'h0, 64'h8000_0000_0001_0000},
    {64'h8000_0000_0001_00F0, 64'h0000_0000_0001_0000, 64'h8000_0000_0000_00F0},
    {64'h0, 64'h30, 64'h8000_0000_0000_00C0},
    {64'h30, 64'h30, 64'h8000_0000_0000_00F0},
    {64'h0, ONES, 64'h0},
    {ONES, 64'h0, ONES},
    {ONES, ONES, 64'h0},
    {64'h0, 64'h0, 64'h0}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    bus_wr = 0; bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  initial begin : wd
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(3'(a), d); chk("R1 reset readback", d, 0); end
    chk("R1 reset irq", {60'd0, irq_l0 | irq_hi}, 0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < 11; i++) begin
      src_i = VEC[i][191:128];
      if (VEC[i][127:64] != 0) begin
        bus_wr = 1; bus_addr = 3'd1; bus_wdata = VEC[i][127:64];
      end
      @(posedge clk); @(negedge clk);
      rd(3'd0, d);
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), d, VEC[i][63:0]);
    end

    // R6 mask load and independence
    wr(3'd2, 64'h1);
    wr(3'd3, 64'h0010_0000);
    wr(3'd4, ONES);
    rd(3'd2, d); chk("R6 mask0", d, 64'h1);
    rd(3'd3, d); chk("R6 mask1", d, 64'h0010_0000);
    rd(3'd4, d); chk("R6 mask2", d, ONES);
    rd(3'd5, d); chk("R6 mask3 untouched", d, 0);

    // R7 R8 request outputs
    chk("R7 idle l0", {60'd0, irq_l0}, 0);
    src_i = 64'h0010_0001;
    @(posedge clk); @(negedge clk);
    src_i = 0;
    chk("R7 irq_l0", {60'd0, irq_l0}, 64'b0101);
    chk("R8 irq_hi", {60'd0, irq_hi}, 64'b0110);

    // R6 read-modify-write of mask0
    rd(3'd2, d);
    wr(3'd2, d | 64'h0010_0000);
    rd(3'd2, d); chk("R6 rmw mask0", d, 64'h0010_0001);
    rd(3'd3, d); chk("R6 rmw mask1 kept", d, 64'h0010_0000);
    chk("R8 irq_hi after rmw", {60'd0, irq_hi}, 64'b0111);

    // R3 partial clear, R7 drop
    wr(3'd1, 64'h1);
    chk("R7 irq_l0 after clear", {60'd0, irq_l0}, 0);
    rd(3'd0, d); chk("R3 partial clear", d, 64'h0010_0000);

    // R9 status write ignored, clear reads zero
    wr(3'd0, ONES);
    rd(3'd0, d); chk("R9 status write ignored", d, 64'h0010_0000);
    rd(3'd1, d); chk("R9 clear reads zero", d, 0);

    // R10 unmapped
    wr(3'd6, ONES);
    wr(3'd7, ONES);
    rd(3'd6, d); chk("R10 addr6 zero", d, 0);
    rd(3'd7, d); chk("R10 addr7 zero", d, 0);
    rd(3'd5, d); chk("R10 mask3 unchanged", d, 0);
    rd(3'd2, d); chk("R10 mask0 unchanged", d, 64'h0010_0001);
    rd(3'd0, d); chk("R10 status unchanged", d, 64'h0010_0000);

    // R2 level held across reset release registers as an edge
    src_i = 64'h4;
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rd(3'd0, d); chk("R1 reset clears status", d, 0);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    rd(3'd0, d); chk("R2 high at reset release", d, 64'h4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule